// File: doc/BRIEF.md
# Return-Address Stack with Per-Mode Flag Banks

This block holds the call and interrupt context of a small 8-bit processor core. It has a return-address stack of six 12-bit levels that works as a shift register, so it needs no pointer. It also holds three carry/zero flag pairs: one for normal code, one for maskable interrupt handlers and one for non-maskable interrupt (NMI) handlers. The instruction sequencer sends one strobe per cycle: subroutine call, interrupt entry, NMI entry, plain return or return-from-interrupt. With the strobe it sends the program-counter value that the stack should save. The ALU sends flag updates, and they are written to the pair of the current execution mode.

The stack saturates quietly at both ends. A seventh push loses the oldest return address. A return on an empty stack gives the next sequential address. A mode switch does not copy flags to memory; it only changes which pair is active. A two-entry mode history covers the case of an NMI that preempts a maskable handler. The stack depth (0 to 6) is a status output.

Top module: `ctx_return_stack`

## Requirements
- R1: A push strobe (call, accepted interrupt entry or accepted NMI entry) puts `pcIn` at the top of the stack at the next clock edge, moves every older level one place deeper, and raises `depth` by one.
- R2: While `retStb` or `retiStb` is high on a non-empty stack, `popPc` shows the top level in that same cycle. At the edge the levels move up one place and `depth` falls by one, so the next return gives the next older address.
- R3: `depth` never goes above 6. A push at depth 6 keeps depth 6 and drops the deepest address, so after seven calls the seven returns give the six newest addresses, newest first.
- R4: A return on an empty stack leaves `depth` at 0, and `popPc` is `pcIn + 1` modulo 4096 (0xFFF gives 0x000).
- R5: After reset `depth` is 0, the core is in NMI mode, and all six flag bits are 0.
- R6: When `flagWr` is high, the carry of the active pair is loaded from `aluCarry` when `carrySel` is 0 and from `bitTest` when `carrySel` is 1, and the zero flag is loaded from `aluZero`. When `flagWr` is low, no flag changes.
- R7: An accepted interrupt entry makes the interrupt pair active, and an accepted NMI entry makes the NMI pair active. Each pair keeps its contents while another pair is active.
- R8: A return-from-interrupt taken in NMI mode goes back to the mode that was active when the NMI was accepted (normal right after reset). One taken in interrupt mode goes back to normal. Either one also pops the stack.
- R9: Interrupt entry is ignored unless the core is in normal mode, and NMI entry is ignored while in NMI mode. An ignored entry pushes nothing and changes neither the mode nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| callStb | input | 1 | Subroutine call: push `pcIn` |
| irqEnter | input | 1 | Maskable interrupt entry: push and switch to the interrupt pair |
| nmiEnter | input | 1 | NMI entry: push and switch to the NMI pair |
| retStb | input | 1 | Plain return: pop |
| retiStb | input | 1 | Return from interrupt: pop and restore the previous mode |
| pcIn | input | 12 | Address to save on a push; base of the fall-through address on an empty pop |
| flagWr | input | 1 | Write enable for the active flag pair |
| carrySel | input | 1 | Carry source: 0 selects the ALU carry, 1 selects the bit-test result |
| aluCarry | input | 1 | Carry/borrow from the ALU |
| bitTest | input | 1 | Value of the tested bit |
| aluZero | input | 1 | ALU result is zero |
| popPc | output | 12 | Return address for the current cycle |
| carryOut | output | 1 | Carry of the active pair |
| zeroOut | output | 1 | Zero flag of the active pair |
| depth | output | 3 | Number of valid stack levels (0 to 6) |

## Verification
The bench goes after the edges of the stack: seven calls followed by seven returns, which a design without saturation would show by wrapping its depth or by returning the lost oldest address; and returns on an empty stack, including the wrap from 0xFFF. An NMI that preempts an interrupt handler is followed by two returns-from-interrupt. A design without mode history would come back to the normal pair too early, and this shows up as carry and zero values taken from the wrong pair. Repeated interrupt entries and an NMI entry taken at reset, when the core is already in NMI mode, are also driven. A design that let these nest would raise the depth or clobber the flags.

// File: rtl/ctxstk_pkg.sv
package ctxstk_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_IRQ    = 2'd1,
    MODE_NMI    = 2'd2
  } execMode_t;

  localparam int NUM_BANKS = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic      push;
    logic      pop;
    logic      flagWr;
    execMode_t bank;
    logic      stackEmpty;
  } stackCmd_t;

endpackage

// File: rtl/ctxstk_ctrl.sv
module ctxstk_ctrl
  import ctxstk_pkg::*;
#(
  parameter int STACK_DEPTH = 6,
  parameter int DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               callStb,
  input  logic               irqEnter,
  input  logic               nmiEnter,
  input  logic               retStb,
  input  logic               retiStb,
  input  logic               flagWr,
  output stackCmd_t          cmd,
  output logic [DEPTH_W-1:0] depth
);

  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(STACK_DEPTH);
  localparam logic [DEPTH_W-1:0] ONE  = DEPTH_W'(1);

  execMode_t mode, nmiPrev;
  logic takeNmi, takeIrq, doCall, doPush, doReti, doRet, doPop;

  // fixed priority: NMI, interrupt, call, reti, ret
  always_comb begin
    takeNmi = nmiEnter && (mode != MODE_NMI);
    takeIrq = irqEnter && (mode == MODE_NORMAL) && !takeNmi;
    doCall  = callStb && !takeNmi && !takeIrq;
    doPush  = takeNmi || takeIrq || doCall;
    doReti  = retiStb && !doPush;
    doRet   = retStb && !doPush && !doReti;
    doPop   = doReti || doRet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_NMI;
      nmiPrev <= MODE_NORMAL;
    end else if (takeNmi) begin
      mode    <= MODE_NMI;
      nmiPrev <= mode;
    end else if (takeIrq) begin
      mode <= MODE_IRQ;
    end else if (doReti) begin
      if (mode == MODE_NMI) mode <= nmiPrev;
      else                  mode <= MODE_NORMAL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
    end else if (doPush) begin
      if (depth != FULL) depth <= depth + ONE;
    end else if (doPop) begin
      if (depth != '0) depth <= depth - ONE;
    end
  end

  always_comb begin
    cmd.push       = doPush;
    cmd.pop        = doPop && (depth != '0);
    cmd.flagWr     = flagWr;
    cmd.bank       = mode;
    cmd.stackEmpty = (depth == '0);
  end

  // R3
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    depth <= FULL);

  // R3
  full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (depth == FULL && callStb) |=> depth == FULL);

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (depth == '0 && (retStb || retiStb) && !callStb && !irqEnter && !nmiEnter)
      |=> depth == '0);

  // R7
  nmi_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nmiEnter && mode != MODE_NMI) |=> mode == MODE_NMI);

  // R9
  irq_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnter && mode != MODE_NORMAL && !nmiEnter && !callStb && !retStb && !retiStb)
      |=> ($stable(depth) && $stable(mode)));

  // R8
  irq_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IRQ && retiStb && !callStb && !irqEnter && !nmiEnter)
      |=> mode == MODE_NORMAL);

endmodule

// File: rtl/ctxstk_dpath.sv
module ctxstk_dpath
  import ctxstk_pkg::*;
#(
  parameter int STACK_DEPTH = 6,
  parameter int PC_WIDTH    = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  stackCmd_t           cmd,
  input  logic [PC_WIDTH-1:0] pcIn,
  input  logic                carrySel,
  input  logic                aluCarry,
  input  logic                bitTest,
  input  logic                aluZero,
  output logic [PC_WIDTH-1:0] popPc,
  output logic                carryOut,
  output logic                zeroOut
);

  logic [PC_WIDTH-1:0] lvl [STACK_DEPTH];
  logic [NUM_BANKS-1:0] carryBank, zeroBank;
  logic carryNext;

  // shift-register stack
  for (genvar i = 0; i < STACK_DEPTH; i++) begin : g_lvl
    logic [PC_WIDTH-1:0] fromAbove, fromBelow;
    if (i == 0) begin : g_top
      assign fromAbove = pcIn;
    end else begin : g_mid
      assign fromAbove = lvl[i-1];
    end
    if (i == STACK_DEPTH - 1) begin : g_bot
      assign fromBelow = '0;
    end else begin : g_up
      assign fromBelow = lvl[i+1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         lvl[i] <= '0;
      else if (cmd.push) lvl[i] <= fromAbove;
      else if (cmd.pop)  lvl[i] <= fromBelow;
    end
  end

  assign carryNext = carrySel ? bitTest : aluCarry;

  // flag banks, one per execution mode
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = cmd.flagWr && (cmd.bank == execMode_t'(b));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        carryBank[b] <= 1'b0;
        zeroBank[b]  <= 1'b0;
      end else if (hit) begin
        carryBank[b] <= carryNext;
        zeroBank[b]  <= aluZero;
      end
    end

    // R6 R7
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(cmd.flagWr && cmd.bank == execMode_t'(b))
        |=> ($stable(carryBank[b]) && $stable(zeroBank[b])));
  end

  always_comb begin
    case (cmd.bank)
      MODE_IRQ: begin carryOut = carryBank[1]; zeroOut = zeroBank[1]; end
      MODE_NMI: begin carryOut = carryBank[2]; zeroOut = zeroBank[2]; end
      default:  begin carryOut = carryBank[0]; zeroOut = zeroBank[0]; end
    endcase
  end

  assign popPc = cmd.stackEmpty ? pcIn + PC_WIDTH'(1) : lvl[0];

  // R1
  push_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |=> lvl[0] == $past(pcIn));

  // R2
  pop_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pop |=> popPc == $past(lvl[1]) || cmd.stackEmpty);

endmodule

// File: rtl/ctx_return_stack.sv
module ctx_return_stack
  import ctxstk_pkg::*;
#(
  parameter int STACK_DEPTH = 6,
  parameter int PC_WIDTH    = 12,
  localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                callStb,
  input  logic                irqEnter,
  input  logic                nmiEnter,
  input  logic                retStb,
  input  logic                retiStb,
  input  logic [PC_WIDTH-1:0] pcIn,
  input  logic                flagWr,
  input  logic                carrySel,
  input  logic                aluCarry,
  input  logic                bitTest,
  input  logic                aluZero,
  output logic [PC_WIDTH-1:0] popPc,
  output logic                carryOut,
  output logic                zeroOut,
  output logic [DEPTH_W-1:0]  depth
);

  stackCmd_t cmd;

  ctxstk_ctrl #(
    .STACK_DEPTH(STACK_DEPTH),
    .DEPTH_W    (DEPTH_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .callStb (callStb),
    .irqEnter(irqEnter),
    .nmiEnter(nmiEnter),
    .retStb  (retStb),
    .retiStb (retiStb),
    .flagWr  (flagWr),
    .cmd     (cmd),
    .depth   (depth)
  );

  ctxstk_dpath #(
    .STACK_DEPTH(STACK_DEPTH),
    .PC_WIDTH   (PC_WIDTH)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .pcIn    (pcIn),
    .carrySel(carrySel),
    .aluCarry(aluCarry),
    .bitTest (bitTest),
    .aluZero (aluZero),
    .popPc   (popPc),
    .carryOut(carryOut),
    .zeroOut (zeroOut)
  );

endmodule

// File: tb/sim_ctx_return_stack.sv
module sim_ctx_return_stack;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic callStb = 0, irqEnter = 0, nmiEnter = 0, retStb = 0, retiStb = 0;
  logic [11:0] pcIn = '0;
  logic flagWr = 0, carrySel = 0, aluCarry = 0, bitTest = 0, aluZero = 0;
  logic [11:0] popPc;
  logic carryOut, zeroOut;
  logic [2:0] depth;

  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  ctx_return_stack u0 (.*);

  // op: 0 idle, 1 call, 2 irq, 3 nmi, 4 ret, 5 reti, 6 flag write
  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [11:0] pc;
    logic [3:0]  fl;      // carrySel, aluCarry, bitTest, aluZero
    logic [11:0] expPop;
    logic        expC;
    logic        expZ;
    logic [2:0]  expD;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VT [NV] = '{
    {4'd6, 3'd6, 12'h000, 4'b0101, 12'h000, 1'b1, 1'b1, 3'd0}, // R6 NMI pair
    {4'd4, 3'd5, 12'h100, 4'b0000, 12'h101, 1'b0, 1'b0, 3'd0}, // R4 R8
    {4'd1, 3'd1, 12'h111, 4'b0000, 12'h000, 1'b0, 1'b0, 3'd1}, // R1
    {4'd6, 3'd6, 12'h000, 4'b1010, 12'h000, 1'b1, 1'b0, 3'd1}, // R6 bit test
    {4'd7, 3'd2, 12'h222, 4'b0000, 12'h000, 1'b0, 1'b0, 3'd2}, // R7
    {4'd6, 3'd6, 12'h000, 4'b0001, 12'h000, 1'b0, 1'b1, 3'd2}, // R6
    {4'd7, 3'd3, 12'h333, 4'b0000, 12'h000, 1'b1, 1'b1, 3'd3}, // R7 kept
    {4'd9, 3'd2, 12'h444, 4'b0000, 12'h000, 1'b1, 1'b1, 3'd3}, // R9
    {4'd8, 3'd5, 12'h000, 4'b0000, 12'h333, 1'b0, 1'b1, 3'd2}, // R8
    {4'd8, 3'd5, 12'h000, 4'b0000, 12'h222, 1'b1, 1'b0, 3'd1}, // R8
    {4'd2, 3'd4, 12'h000, 4'b0000, 12'h111, 1'b1, 1'b0, 3'd0}, // R2
    {4'd4, 3'd4, 12'h7FF, 4'b0000, 12'h800, 1'b1, 1'b0, 3'd0}, // R4
    {4'd1, 3'd1, 12'h001, 4'b0000, 12'h000, 1'b1, 1'b0, 3'd1}, // R1
    {4'd1, 3'd1, 12'h002, 4'b0000, 12'h000, 1'b1, 1'b0, 3'd2},
    {4'd1, 3'd1, 12'h003, 4'b0000, 12'h000, 1'b1, 1'b0, 3'd3},
    {4'd1, 3'd1, 12'h004, 4'b0000, 12'h000, 1'b1, 1'b0, 3'd4},
    {4'd1, 3'd1, 12'h005, 4'b0000, 12'h000, 1'b1, 1'b0, 3'd5},
    {4'd1, 3'd1, 12'h006, 4'b0000, 12'h000, 1'b1, 1'b0, 3'd6},
    {4'd3, 3'd1, 12'h007, 4'b0000, 12'h000, 1'b1, 1'b0, 3'd6}, // R3
    {4'd3, 3'd4, 12'h000, 4'b0000, 12'h007, 1'b1, 1'b0, 3'd5}, // R3
    {4'd2, 3'd4, 12'h000, 4'b0000, 12'h006, 1'b1, 1'b0, 3'd4},
    {4'd2, 3'd4, 12'h000, 4'b0000, 12'h005, 1'b1, 1'b0, 3'd3},
    {4'd2, 3'd4, 12'h000, 4'b0000, 12'h004, 1'b1, 1'b0, 3'd2},
    {4'd2, 3'd4, 12'h000, 4'b0000, 12'h003, 1'b1, 1'b0, 3'd1},
    {4'd3, 3'd4, 12'h000, 4'b0000, 12'h002, 1'b1, 1'b0, 3'd0}, // R3 oldest lost
    {4'd4, 3'd4, 12'hFFF, 4'b0000, 12'h000, 1'b1, 1'b0, 3'd0}, // R4 wrap
    {4'd7, 3'd2, 12'h050, 4'b0000, 12'h000, 1'b0, 1'b1, 3'd1}, // R7
    {4'd9, 3'd2, 12'h055, 4'b0000, 12'h000, 1'b0, 1'b1, 3'd1}, // R9
    {4'd1, 3'd1, 12'h060, 4'b0000, 12'h000, 1'b0, 1'b1, 3'd2}, // R1
    {4'd2, 3'd4, 12'h000, 4'b0000, 12'h060, 1'b0, 1'b1, 3'd1}, // R2
    {4'd8, 3'd5, 12'h000, 4'b0000, 12'h050, 1'b1, 1'b0, 3'd0}  // R8
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    callStb  = (v.op == 3'd1);
    irqEnter = (v.op == 3'd2);
    nmiEnter = (v.op == 3'd3);
    retStb   = (v.op == 3'd4);
    retiStb  = (v.op == 3'd5);
    flagWr   = (v.op == 3'd6);
    pcIn     = v.pc;
    {carrySel, aluCarry, bitTest, aluZero} = v.fl;
  endtask

  task automatic idle();
    {callStb, irqEnter, nmiEnter, retStb, retiStb, flagWr} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    // R5 reset state
    check("R5", "depth", depth, 0);
    check("R5", "carry", carryOut, 0);
    check("R5", "zero", zeroOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R9 NMI entry while already in NMI mode
    nmiEnter = 1'b1; pcIn = 12'h0AA;
    @(posedge clk); #1;
    check("R9", "depth after NMI in NMI", depth, 0);
    @(negedge clk); idle();
    // R6 inputs toggling without flagWr leave flags alone
    {carrySel, aluCarry, bitTest, aluZero} = 4'b0111;
    @(posedge clk); #1;
    check("R6", "carry no write", carryOut, 0);
    check("R6", "zero no write", zeroOut, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      tag = $sformatf("R%0d step%0d", VT[i].req, i);
      #1;
      if (VT[i].op == 3'd4 || VT[i].op == 3'd5)
        check(tag, "popPc", popPc, VT[i].expPop);
      @(posedge clk); #1;
      check(tag, "depth", depth, VT[i].expD);
      check(tag, "carry", carryOut, VT[i].expC);
      check(tag, "zero", zeroOut, VT[i].expZ);
    end

    // R5 reset mid-run after pushes and flag writes
    @(negedge clk); idle();
    callStb = 1'b1; pcIn = 12'h321;
    @(negedge clk); idle();
    flagWr = 1'b1; {carrySel, aluCarry, bitTest, aluZero} = 4'b0101;
    @(negedge clk); idle();
    rstN = 1'b0;
    #1;
    check("R5", "depth after reset", depth, 0);
    check("R5", "carry after reset", carryOut, 0);
    check("R5", "zero after reset", zeroOut, 0);
    pcIn = 12'h010;
    #1;
    check("R4", "popPc empty after reset", popPc, 12'h011);
    @(negedge clk);
    rstN = 1'b1;

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule